// File: doc/BRIEF.md
# Direction-Programmable GPIO Bank with Change Flag

This block drives and senses a bank of general-purpose I/O lines behind two memory-mapped registers. The direction register chooses, line by line, whether a line drives its output or listens. The data register holds the values driven on output lines. A read of the data register returns the present state of every line. For an output line this is the driven value. For an input line it is the synchronised pin value.

Each input passes through a two-flop synchroniser and is then sampled on every system clock. A sampled input is compared with its sample from the clock before. Any difference on a line set as an input raises one sticky change flag, which can serve as an interrupt request. The flag stays set until software reads the data register. If a new change arrives in the same cycle as that read, the change wins and no event is lost. External tristate buffers and pad levels are not part of the block. It only provides output-enable, output-value and input-value vectors and the flag.

Top module: `pinbank_gpio`

## Requirements
- R1: After a synchronous active-low reset, every line is an input (`pin_oe` all zero), `pin_out` is all zero and `chg_flag` is 0.
- R2: A write to address 0xFA800000 loads the direction register from `wdata[23:0]` on that clock edge. Bit n = 1 makes line n an output, so `pin_oe[n]` = 1 from the next cycle. A read of that address returns the register in bits 23:0 and zeros above.
- R3: A write to address 0xFA000000 loads `pin_out` from `wdata[23:0]` on that clock edge. `wdata[31:24]` has no effect. A write to any other address changes neither register.
- R4: A read of address 0xFA000000 returns, in bit n, `pin_out[n]` when line n is an output and the synchronised `pin_in[n]` when it is an input. Bits 31:24 read as zero. A pin change first shows in the readback after two clock edges.
- R5: A level change on an input line that is present at a clock edge sets `chg_flag` on the third clock edge after it appears on `pin_in`. A pulse that lasts one clock period is enough.
- R6: A change on a line set as an output does not set `chg_flag`.
- R7: `chg_flag` stays set through idle cycles, through register writes and through reads of the direction register.
- R8: A read of the data register clears `chg_flag` on that clock edge, unless R9 applies.
- R9: If a new input change is detected in the same cycle as a clearing read of the data register, `chg_flag` is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 32 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| pin_in | input | 24 | Raw pin levels, asynchronous |
| pin_oe | output | 24 | Per-line output enable (1 = drive) |
| pin_out | output | 24 | Per-line output value |
| chg_flag | output | 1 | Sticky input-change flag |

## Verification
The readback is tried with mixed direction masks: all inputs, all outputs, alternating lines and arbitrary masks. Each mask pairs pin and output values that disagree, so each readback bit shows whether the design picked the driven value or the sampled pin for that line. The change flag is tried with a single input edge, timed edge by edge. It is also tried with a one-cycle pulse and with toggling only output-configured lines, which separates masked from unmasked detection. A change that coincides with the clearing read shows whether set takes priority over clear. Reads of the direction register and write-only traffic show that only a data read clears the flag.

// File: rtl/pinbank_gpio_pkg.sv
// Package: shared types for the GPIO bank.
// Assumes: one register access at most per cycle.
package pinbank_gpio_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_DATA = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/pinbank_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous pins.
// Assumes: each bit is synchronised on its own. Bits that change together
// may land one cycle apart. STAGES >= 2.
module pinbank_sync #(
    parameter int WIDTH  = 24,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stg [STAGES];

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= raw_in;
    end

    // Later stages shift the sample along the chain.
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
        end
    end

    assign sync_out = stg[LAST];
endmodule

// File: rtl/pinbank_regs.sv
// Module: direction and output-value registers of the GPIO bank.
// Assumes: the enables come from an already decoded address and are never
// both high.
module pinbank_regs #(
    parameter int WIDTH  = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_we,
    input  logic              out_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  out_q
);
    // Direction register: reset to all inputs.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (dir_we) dir_q <= wdata[WIDTH-1:0];
    end

    // Output-value register: reset to all zeros.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_q <= '0;
        else if (out_we) out_q <= wdata[WIDTH-1:0];
    end

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dir_we |=> dir_q == $past(wdata[WIDTH-1:0]));

    assert_out_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |=> out_q == $past(wdata[WIDTH-1:0]));

    assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_we |=> $stable(out_q));
endmodule

// File: rtl/pinbank_chg_detect.sv
// Module: edge detector over the synchronised inputs plus a sticky flag.
// Assumes: sync_val is already in the clock domain. Lines whose dir bit is
// 1 are ignored. When set and clear coincide, set wins.
module pinbank_chg_detect #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_val,
    input  logic [WIDTH-1:0] dir,
    input  logic             clr,
    output logic             flag
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] diff;
    logic             hit;

    // Keep last cycle's sample for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_val;
    end

    // Per-line change, masked to input lines.
    always_comb begin
        diff = (sync_val ^ prev_q) & ~dir;
        hit  = |diff;
    end

    // Sticky flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (hit) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    assert_change_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_val != prev_q) && ((sync_val ^ prev_q) & ~dir) != '0 |=> flag);

    assert_output_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !flag && ((sync_val ^ prev_q) & ~dir) == '0 |=> !flag);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clr |=> flag);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr && ((sync_val ^ prev_q) & ~dir) == '0 |=> !flag);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr && ((sync_val ^ prev_q) & ~dir) != '0 |=> flag);
endmodule

// File: rtl/pinbank_gpio.sv
// Module: top of the GPIO bank. Decodes the two register addresses, forms
// the readback and ties the synchroniser, registers and detector together.
// Assumes: single-cycle strobes, combinational read data, one access per
// cycle. Reading the data register is the only way to clear the flag.
module pinbank_gpio #(
    parameter int          WIDTH     = 24,
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter int          SYNC_STG  = 2,
    parameter logic [31:0] DIR_ADDR  = 32'hFA80_0000,
    parameter logic [31:0] DATA_ADDR = 32'hFA00_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  pin_out,
    output logic              chg_flag
);
    import pinbank_gpio_pkg::*;

    reg_sel_e         sel;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] out_q;
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] view;
    logic             data_rd;

    // Address decode into a register select.
    always_comb begin
        if (bus_addr == DIR_ADDR[ADDR_W-1:0])       sel = SEL_DIR;
        else if (bus_addr == DATA_ADDR[ADDR_W-1:0]) sel = SEL_DATA;
        else                                        sel = SEL_NONE;
    end

    assign data_rd = bus_rd && (sel == SEL_DATA);

    pinbank_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pin_in),
        .sync_out (pin_sync)
    );

    pinbank_regs #(.WIDTH(WIDTH), .DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .dir_we (bus_wr && (sel == SEL_DIR)),
        .out_we (bus_wr && (sel == SEL_DATA)),
        .wdata  (bus_wdata),
        .dir_q  (dir_q),
        .out_q  (out_q)
    );

    pinbank_chg_detect #(.WIDTH(WIDTH)) u_chg (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_val (pin_sync),
        .dir      (dir_q),
        .clr      (data_rd),
        .flag     (chg_flag)
    );

    // Line state: driven value for outputs, sampled pin for inputs.
    always_comb view = (dir_q & out_q) | (~dir_q & pin_sync);

    // Read data multiplexer, zero-extended.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_DIR:  bus_rdata[WIDTH-1:0] = dir_q;
            SEL_DATA: bus_rdata[WIDTH-1:0] = view;
            default:  bus_rdata = '0;
        endcase
    end

    assign pin_oe  = dir_q;
    assign pin_out = out_q;

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0) && (pin_out == '0) && !chg_flag);

    assert_oe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && (bus_addr == DIR_ADDR[ADDR_W-1:0])
        |=> pin_oe == $past(bus_wdata[WIDTH-1:0]));
endmodule

// File: tb/sim_pinbank_gpio.sv
module sim_pinbank_gpio;
    localparam logic [31:0] A_DIR  = 32'hFA80_0000;
    localparam logic [31:0] A_DATA = 32'hFA00_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [23:0] pin_in = '0;
    logic [23:0] pin_oe;
    logic [23:0] pin_out;
    logic        chg_flag;

    int checks = 0;
    int errors = 0;

    // Vector table: {dir, out, pins}
    localparam int NV = 6;
    localparam logic [71:0] VEC [NV] = '{
        {24'h000000, 24'hFFFFFF, 24'hA5C3F0},
        {24'hFFFFFF, 24'h123456, 24'hEDCBA9},
        {24'hAAAAAA, 24'hFFFFFF, 24'h000000},
        {24'h555555, 24'h000000, 24'hFFFFFF},
        {24'hF0F00F, 24'h3C3C3C, 24'hC3C3C3},
        {24'h000001, 24'h000001, 24'h800000}
    };

    pinbank_gpio u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .chg_flag(chg_flag)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [23:0] dv, ov, pv;
        idle(3);
        // R1 reset state
        chk("R1 pin_oe", {8'h0, pin_oe}, 32'h0);
        chk("R1 pin_out", {8'h0, pin_out}, 32'h0);
        chk("R1 chg_flag", {31'h0, chg_flag}, 32'h0);
        rst_n = 1'b1;
        idle(2);
        bus_read(A_DIR, rd);
        chk("R1 dir readback", rd, 32'h0);

        // Table walk: R2, R3, R4
        for (int v = 0; v < NV; v++) begin
            dv = VEC[v][71:48]; ov = VEC[v][47:24]; pv = VEC[v][23:0];
            bus_write(A_DIR, {8'hFF, dv});
            bus_write(A_DATA, {8'hEE, ov});
            pin_in = pv;
            idle(3);
            chk("R2 pin_oe", {8'h0, pin_oe}, {8'h0, dv});
            chk("R3 pin_out", {8'h0, pin_out}, {8'h0, ov});
            bus_read(A_DATA, rd);
            chk("R4 readback", rd, {8'h0, (dv & ov) | (~dv & pv)});
        end
        bus_read(A_DIR, rd);
        chk("R2 dir readback", rd, {8'h0, 24'h000001});

        // R3: stray address write changes nothing
        bus_write(32'hFB00_0000, 32'h00FFFFFF);
        idle(1);
        chk("R3 stray write oe", {8'h0, pin_oe}, 32'h000001);
        chk("R3 stray write out", {8'h0, pin_out}, 32'h000001);

        // All inputs, quiet, clear flag
        bus_write(A_DIR, 32'h0);
        pin_in = 24'h0;
        idle(4);
        bus_read(A_DATA, rd);
        chk("R8 flag cleared by data read", {31'h0, chg_flag}, 32'h0);

        // R5 / R4: edge-by-edge timing of one change
        pin_in = 24'h000100;
        @(negedge clk);
        chk("R5 flag after edge 1", {31'h0, chg_flag}, 32'h0);
        chk("R4 readback after one edge", bus_rdata, 32'h0);
        @(negedge clk);
        chk("R5 flag after edge 2", {31'h0, chg_flag}, 32'h0);
        chk("R4 readback after two edges", bus_rdata, 32'h000100);
        @(negedge clk);
        chk("R5 flag after edge 3", {31'h0, chg_flag}, 32'h1);

        // R7: sticky through idle, dir reads and writes
        idle(5);
        bus_read(A_DIR, rd);
        bus_write(A_DATA, 32'h0);
        chk("R7 flag sticky", {31'h0, chg_flag}, 32'h1);

        // R8: data read clears
        bus_read(A_DATA, rd);
        chk("R8 flag cleared", {31'h0, chg_flag}, 32'h0);

        // R5: one-cycle pulse
        pin_in = 24'h000102;
        @(negedge clk);
        pin_in = 24'h000100;
        idle(4);
        chk("R5 one-cycle pulse caught", {31'h0, chg_flag}, 32'h1);
        bus_read(A_DATA, rd);
        chk("R8 cleared after pulse", {31'h0, chg_flag}, 32'h0);

        // R6: toggling output lines only
        bus_write(A_DIR, 32'h00FF0000);
        idle(3);
        bus_read(A_DATA, rd);
        pin_in = 24'hFF0100;
        idle(4);
        pin_in = 24'h5A0100;
        idle(4);
        chk("R6 output lines masked", {31'h0, chg_flag}, 32'h0);
        pin_in = 24'h5A0101;
        idle(4);
        chk("R6 input line still detected", {31'h0, chg_flag}, 32'h1);
        bus_read(A_DATA, rd);

        // R9: change detected in the cycle of a clearing read
        pin_in = 24'h5A0103;
        @(negedge clk);
        @(negedge clk);
        bus_addr = A_DATA; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R9 set wins over clear", {31'h0, chg_flag}, 32'h1);
        bus_read(A_DATA, rd);
        chk("R9 next read clears", {31'h0, chg_flag}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule